// File: doc/BRIEF.md
# Saturating Double-to-Word Converter

This block turns an IEEE-754 double-precision operand into a 32-bit word. It has four conversion modes. The result is either signed (two's complement) or unsigned. It is also either an integer or a fixed-point fraction. A fraction scales the operand by 2^32 when unsigned and by 2^31 when signed. Values outside the range of the chosen mode saturate to the nearest representable limit.

Special inputs return fixed codes and raise flags:

- NaN, infinity and denormal operands return fixed codes and raise an invalid flag.
- In unsigned mode, a negative operand returns zero and raises an overflow flag.

For a finite operand that is in range, the block reports three things about the dropped bits: the guard bit, the sticky bit and an inexact indication. It can round the result in one of four directions. Rounding happens only when rounding is requested and the inexact exception is not enabled.

Operands enter on a valid/ready stream, together with their mode bits. Results leave one cycle later on a second valid/ready stream.

The output stage holds a single entry:

- While that entry has not been taken, `in_ready` is low.
- A new operand is accepted in the same cycle that the waiting result is taken, so a continuous stream runs at one operand per cycle.
- While `out_valid` is high and `out_ready` is low, the result and all flags are held unchanged.

Top module: `dbl2word_cvt`

## Requirements
- R1: An operand with exponent field 0x7FF and a nonzero fraction (NaN, quiet or signalling) gives result 0x00000000 with the invalid flag set and the overflow flag clear.
- R2: An operand with exponent field 0x7FF and zero fraction (infinity) sets the invalid flag. In signed mode the result is 0x80000000 when bit 63 is one and 0x7FFFFFFF when it is zero. In unsigned mode the result is 0x00000000 when bit 63 is one and 0xFFFFFFFF when it is zero.
- R3: An operand with exponent field zero and a nonzero fraction (denormal) gives 0x00000000 with the invalid flag set, whatever its sign.
- R4: In unsigned mode, any other operand with bit 63 set, including negative zero, gives 0x00000000 with the overflow flag set.
- R5: Positive zero in any mode, and negative zero in signed mode, give 0x00000000 with every flag clear.
- R6: In integer mode the largest accepted biased exponent is 1054 for unsigned results and 1053 for signed results. The one exception is the value exactly -2^31 (exponent 1054, zero fraction, sign one), which is accepted and gives 0x80000000 with no overflow.
- R7: In fractional mode the largest accepted biased exponent is 1022. The result is the operand times 2^32 in unsigned mode and times 2^31 in signed mode, with the dropped bits handled as in R9.
- R8: An exponent above the limit of the mode sets the overflow flag. The result is then 0xFFFFFFFF in unsigned mode. In signed mode it is 0x80000000 for a negative operand and 0x7FFFFFFF for a positive one.
- R9: For an in-range finite operand, `out_guard` is the first bit below the least significant bit of the result, `out_sticky` is the OR of every lower bit, and `out_inexact` is their OR. When more than 33 positions are dropped, guard is zero and sticky is one. All three are zero for the inputs covered by R1 to R5 and R8.
- R10: Rounding acts on the magnitude, and only when `in_round` is 1 and `in_inx_en` is 0. The `in_rmode` codes are: 00 rounds to nearest with ties to even; 01 rounds toward zero; 10 rounds toward plus infinity; 11 rounds toward minus infinity. The sign is applied by two's-complement negation after rounding. The guard, sticky and inexact outputs report the bits before rounding.
- R11: If a rounding increment pushes the magnitude past the limit of the mode, the result saturates to that limit and the overflow flag is set. The limits are 0x7FFFFFFF for signed positive, 0x80000000 for signed negative and 0xFFFFFFFF for unsigned.
- R12: An operand is accepted when `in_valid` and `in_ready` are both high. Its result appears with `out_valid` on the next cycle. `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid` is high and `out_ready` is low, the result and flags hold steady.
- R13: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken |
| in_op | input | 64 | Double-precision operand |
| in_signed | input | 1 | 1: signed result, 0: unsigned |
| in_frac | input | 1 | 1: fractional result, 0: integer |
| in_round | input | 1 | Rounding requested |
| in_rmode | input | 2 | Rounding direction (see R10) |
| in_inx_en | input | 1 | Inexact exception enabled; suppresses rounding |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result taken by the consumer |
| out_res | output | 32 | Converted word |
| out_inv | output | 1 | Invalid operand flag |
| out_ovf | output | 1 | Overflow / saturation flag |
| out_guard | output | 1 | Guard bit of the dropped part |
| out_sticky | output | 1 | Sticky bit of the dropped part |
| out_inexact | output | 1 | Guard OR sticky |

## Verification
The directed corner cases target the following faults:

- **The single accepted -2^31 in signed integer mode.** A design with the wrong exponent limit would report overflow on it or accept +2^31.
- **Negative zero in unsigned mode.** A design that tests for zero first would return it silently, without the overflow flag.
- **Rounding ties and carries.** A wrong tie rule turns 2.5 into 3. A missing carry check wraps a value just below the signed fractional limit to 0x80000000 instead of saturating.
- **Shifts of 32 positions or more.** These must move guard into sticky correctly; an undersized shifter would leak mantissa bits into the result.

Constrained-random operands concentrate exponents near every mode limit, and the back-pressure case checks that a held result does not change while the consumer stalls.

// File: rtl/dbl2word_pkg.sv
package dbl2word_pkg;
  localparam int EXP_W        = 11;
  localparam int FRAC_W       = 52;
  localparam int OP_W         = 1 + EXP_W + FRAC_W;
  localparam int RES_W        = 32;
  localparam int SH_W         = $clog2(2 * RES_W) + 1;
  localparam int WIDE_W       = 2 * RES_W;
  localparam int EXP_LIM_INT  = 1054;
  localparam int EXP_LIM_FRAC = 1022;
  localparam int CALC_W       = EXP_W + 2;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_TOZERO  = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_e;

  typedef enum logic [2:0] {
    CL_NAN, CL_INF, CL_DENORM, CL_NEG_UNS, CL_ZERO, CL_OVER, CL_NORMAL
  } class_e;

  typedef struct packed {
    logic [RES_W-1:0] res;
    logic             inv;
    logic             ovf;
    logic             guard;
    logic             sticky;
    logic             inexact;
  } result_t;

  function automatic logic [RES_W-1:0] sat_word(input logic is_signed, input logic neg);
    if (is_signed) return neg ? {1'b1, {(RES_W-1){1'b0}}} : {1'b0, {(RES_W-1){1'b1}}};
    return neg ? '0 : '1;
  endfunction
endpackage

// File: rtl/dbl2word_classify.sv
module dbl2word_classify
  import dbl2word_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            is_signed,
  input  logic            is_frac,
  output class_e          cls,
  output logic [SH_W-1:0] shamt
);
  logic              sgn;
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic [CALC_W-1:0] lim, sh;
  logic              exact_min;

  assign sgn = op[OP_W-1];
  assign e   = op[OP_W-2 -: EXP_W];
  assign f   = op[FRAC_W-1:0];

  always_comb begin
    exact_min = (e == EXP_W'(EXP_LIM_INT)) && (f == '0) && sgn;
    if (is_frac) begin
      lim = CALC_W'(EXP_LIM_FRAC);
      sh  = CALC_W'(EXP_LIM_FRAC) - CALC_W'(e) + CALC_W'(is_signed);
    end else begin
      lim = CALC_W'(EXP_LIM_INT) - CALC_W'(is_signed && !exact_min);
      sh  = CALC_W'(EXP_LIM_INT) - CALC_W'(e);
    end
    shamt = (sh > CALC_W'(WIDE_W)) ? SH_W'(WIDE_W) : sh[SH_W-1:0];

    if (e == '1)                       cls = (f != '0) ? CL_NAN : CL_INF;
    else if (e == '0 && f != '0)       cls = CL_DENORM;
    else if (!is_signed && sgn)        cls = CL_NEG_UNS;
    else if (e == '0)                  cls = CL_ZERO;
    else if (CALC_W'(e) > lim)         cls = CL_OVER;
    else                               cls = CL_NORMAL;
  end
endmodule

// File: rtl/dbl2word_align.sv
module dbl2word_align
  import dbl2word_pkg::*;
(
  input  logic [RES_W-1:0] mant,
  input  logic             g_in,
  input  logic             s_in,
  input  logic [SH_W-1:0]  shamt,
  output logic [RES_W-1:0] mag,
  output logic             guard,
  output logic             sticky
);
  logic [WIDE_W-1:0] wide, shifted, lost_mask;

  always_comb begin
    wide      = {mant, g_in, {(RES_W-1){1'b0}}};
    shifted   = wide >> shamt;
    lost_mask = (shamt >= SH_W'(WIDE_W)) ? '1 : ((WIDE_W'(1) << shamt) - WIDE_W'(1));
    mag       = shifted[WIDE_W-1 -: RES_W];
    guard     = shifted[RES_W-1];
    sticky    = s_in | (|shifted[RES_W-2:0]) | (|(wide & lost_mask));
  end
endmodule

// File: rtl/dbl2word_round.sv
module dbl2word_round
  import dbl2word_pkg::*;
(
  input  logic [RES_W-1:0] mag,
  input  logic             guard,
  input  logic             sticky,
  input  logic             neg,
  input  logic             is_signed,
  input  logic             do_round,
  input  logic [1:0]       rmode,
  output logic [RES_W-1:0] res,
  output logic             sat
);
  logic           inc;
  logic [RES_W:0] sum, lim;

  always_comb begin
    inc = 1'b0;
    if (do_round) begin
      case (rmode_e'(rmode))
        RM_NEAREST: inc = guard & (sticky | mag[0]);
        RM_TOZERO:  inc = 1'b0;
        RM_UP:      inc = (guard | sticky) & ~neg;
        RM_DOWN:    inc = (guard | sticky) & neg;
        default:    inc = 1'b0;
      endcase
    end
    sum = {1'b0, mag} + (RES_W+1)'(inc);
    lim = {1'b0, sat_word(is_signed, 1'b0)} + (RES_W+1)'(is_signed & neg);
    sat = sum > lim;
    if (sat) sum = lim;
    res = (is_signed && neg) ? (~sum[RES_W-1:0] + RES_W'(1)) : sum[RES_W-1:0];
  end
endmodule

// File: rtl/dbl2word_cvt.sv
module dbl2word_cvt
  import dbl2word_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic              in_signed,
  input  logic              in_frac,
  input  logic              in_round,
  input  logic [1:0]        in_rmode,
  input  logic              in_inx_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RES_W-1:0]  out_res,
  output logic              out_inv,
  output logic              out_ovf,
  output logic              out_guard,
  output logic              out_sticky,
  output logic              out_inexact
);
  class_e           cls;
  logic [SH_W-1:0]  shamt;
  logic [RES_W-1:0] mag, rnd_res;
  logic             a_guard, a_sticky, rnd_sat, neg, accept;
  result_t          nxt, cur;

  assign neg      = in_op[OP_W-1];
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  dbl2word_classify u_cls (
    .op(in_op), .is_signed(in_signed), .is_frac(in_frac), .cls(cls), .shamt(shamt)
  );

  dbl2word_align u_align (
    .mant({1'b1, in_op[FRAC_W-1 -: RES_W-1]}),
    .g_in(in_op[FRAC_W-RES_W]),
    .s_in(|in_op[FRAC_W-RES_W-1:0]),
    .shamt(shamt), .mag(mag), .guard(a_guard), .sticky(a_sticky)
  );

  dbl2word_round u_round (
    .mag(mag), .guard(a_guard), .sticky(a_sticky), .neg(neg), .is_signed(in_signed),
    .do_round(in_round && !in_inx_en), .rmode(in_rmode), .res(rnd_res), .sat(rnd_sat)
  );

  always_comb begin
    nxt = '0;
    case (cls)
      CL_NAN:     nxt.inv = 1'b1;
      CL_INF:     begin nxt.inv = 1'b1; nxt.res = sat_word(in_signed, neg); end
      CL_DENORM:  nxt.inv = 1'b1;
      CL_NEG_UNS: nxt.ovf = 1'b1;
      CL_ZERO:    nxt = '0;
      CL_OVER:    begin nxt.ovf = 1'b1; nxt.res = sat_word(in_signed, neg && in_signed); end
      default: begin
        nxt.res     = rnd_res;
        nxt.ovf     = rnd_sat;
        nxt.guard   = a_guard;
        nxt.sticky  = a_sticky;
        nxt.inexact = a_guard | a_sticky;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cur       <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept)   cur       <= nxt;
    end
  end

  assign out_res     = cur.res;
  assign out_inv     = cur.inv;
  assign out_ovf     = cur.ovf;
  assign out_guard   = cur.guard;
  assign out_sticky  = cur.sticky;
  assign out_inexact = cur.inexact;

  AST_NAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cls == CL_NAN |=> out_res == '0 && out_inv && !out_ovf); // R1
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_inv, out_ovf})); // R2
  AST_UNS_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cls == CL_NEG_UNS |=> out_res == '0 && out_ovf); // R4
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cls == CL_ZERO |=> out_res == '0 && !out_inv && !out_ovf && !out_inexact); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_ovf) && $stable(out_inexact)); // R12
  AST_FAR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    cls == CL_NORMAL && shamt > SH_W'(RES_W+1) |-> !a_guard && a_sticky && mag == '0); // R9
endmodule

// File: tb/dbl2word_cvt_tb.sv
module dbl2word_cvt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [63:0] in_op = '0;
  logic        in_signed = 1'b0, in_frac = 1'b0, in_round = 1'b0, in_inx_en = 1'b0;
  logic [1:0]  in_rmode = 2'b00;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] out_res;
  logic        out_inv, out_ovf, out_guard, out_sticky, out_inexact;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  dbl2word_cvt dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_signed(in_signed), .in_frac(in_frac), .in_round(in_round), .in_rmode(in_rmode),
    .in_inx_en(in_inx_en), .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_inv(out_inv), .out_ovf(out_ovf), .out_guard(out_guard), .out_sticky(out_sticky),
    .out_inexact(out_inexact)
  );

  // expected {res, inv, ovf, guard, sticky, inexact}, bit-serial shift model
  function automatic logic [36:0] model(input logic [63:0] op, input logic sg, input logic fr,
                                        input logic rn, input logic [1:0] rm, input logic xe);
    logic s = op[63];
    int e = int'(op[62:52]);
    logic [51:0] f = op[51:0];
    logic [32:0] r, lim;
    logic g, st, inv, ovf, inc;
    int maxe, sh;
    inv = 0; ovf = 0; g = 0; st = 0;
    if (e == 2047) begin
      inv = 1;
      if (f != 0) r = 0;
      else if (sg) r = s ? 33'h080000000 : 33'h07FFFFFFF;
      else r = s ? 33'h0 : 33'h0FFFFFFFF;
      return {r[31:0], inv, ovf, 3'b000};
    end
    if (e == 0 && f != 0) return {32'h0, 1'b1, 1'b0, 3'b000};
    if (!sg && s) return {32'h0, 1'b0, 1'b1, 3'b000};
    if (e == 0) return 37'h0;
    if (!fr) begin
      maxe = 1054; sh = 1054 - e;
      if (sg && !(e == 1054 && f == 0 && s)) maxe = 1053;
    end else begin
      maxe = 1022; sh = 1022 - e + (sg ? 1 : 0);
    end
    if (e > maxe) begin
      r = sg ? (s ? 33'h080000000 : 33'h07FFFFFFF) : 33'h0FFFFFFFF;
      return {r[31:0], 1'b0, 1'b1, 3'b000};
    end
    r = {1'b0, 1'b1, f[51:21]}; g = f[20]; st = |f[19:0];
    for (int n = 0; n < sh && n < 40; n++) begin
      st = st | g; g = r[0]; r = r >> 1;
    end
    inc = 0;
    if (rn && !xe) begin
      case (rm)
        2'b00: inc = g & (st | r[0]);
        2'b10: inc = (g | st) & ~s;
        2'b11: inc = (g | st) & s;
        default: inc = 0;
      endcase
    end
    r = r + 33'(inc);
    lim = sg ? (s ? 33'h080000000 : 33'h07FFFFFFF) : 33'h0FFFFFFFF;
    if (r > lim) begin r = lim; ovf = 1; end
    if (sg && s) r = ~r + 33'd1;
    return {r[31:0], inv, ovf, g, st, g | st};
  endfunction

  task automatic chk(input string tag, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [63:0] op, input logic sg, input logic fr,
                     input logic rn, input logic [1:0] rm, input logic xe,
                     input logic lit_en, input logic [31:0] lit);
    logic [36:0] exp;
    @(negedge clk);
    in_op = op; in_signed = sg; in_frac = fr; in_round = rn; in_rmode = rm; in_inx_en = xe;
    in_valid = 1'b1; out_ready = 1'b1;
    exp = model(op, sg, fr, rn, rm, xe);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {36'h0, out_valid}, 37'h1);
    chk(tag, {out_res, out_inv, out_ovf, out_guard, out_sticky, out_inexact}, exp);
    if (lit_en) chk({tag, " literal"}, {5'h0, out_res}, {5'h0, lit});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [36:0] e1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R13 reset", {35'h0, out_valid, in_ready}, 37'h1);
    rst_n = 1'b1;

    run("R7 one", 64'h3FF0000000000000, 1, 0, 0, 0, 0, 1, 32'h1);
    run("R1 qnan", 64'h7FF8000000000001, 1, 0, 1, 0, 0, 1, 32'h0);
    run("R1 snan", 64'hFFF0000000000001, 0, 1, 0, 0, 0, 1, 32'h0);
    run("R2 +inf signed", 64'h7FF0000000000000, 1, 0, 0, 0, 0, 1, 32'h7FFFFFFF);
    run("R2 -inf unsigned", 64'hFFF0000000000000, 0, 0, 0, 0, 0, 1, 32'h0);
    run("R2 +inf unsigned", 64'h7FF0000000000000, 0, 1, 0, 0, 0, 1, 32'hFFFFFFFF);
    run("R3 denorm", 64'h8000000000000001, 1, 0, 0, 0, 0, 1, 32'h0);
    run("R4 -1 unsigned", 64'hBFF0000000000000, 0, 0, 0, 0, 0, 1, 32'h0);
    run("R4 -0 unsigned", 64'h8000000000000000, 0, 0, 0, 0, 0, 1, 32'h0);
    run("R5 -0 signed", 64'h8000000000000000, 1, 1, 0, 0, 0, 1, 32'h0);
    run("R6 min exact", 64'hC1E0000000000000, 1, 0, 0, 0, 0, 1, 32'h80000000);
    run("R8 +2^31 signed", 64'h41E0000000000000, 1, 0, 0, 0, 0, 1, 32'h7FFFFFFF);
    run("R6 +2^31 unsigned", 64'h41E0000000000000, 0, 0, 0, 0, 0, 1, 32'h80000000);
    run("R8 2^32 unsigned", 64'h41F0000000000000, 0, 0, 0, 0, 0, 1, 32'hFFFFFFFF);
    run("R7 half unsigned", 64'h3FE0000000000000, 0, 1, 0, 0, 0, 1, 32'h80000000);
    run("R7 half signed", 64'h3FE0000000000000, 1, 1, 0, 0, 0, 1, 32'h40000000);
    run("R8 one frac", 64'h3FF0000000000000, 0, 1, 0, 0, 0, 1, 32'hFFFFFFFF);
    run("R10 2.5 nearest", 64'h4004000000000000, 1, 0, 1, 2'b00, 0, 1, 32'h2);
    run("R10 3.5 nearest", 64'h400C000000000000, 1, 0, 1, 2'b00, 0, 1, 32'h4);
    run("R10 2.5 up", 64'h4004000000000000, 1, 0, 1, 2'b10, 0, 1, 32'h3);
    run("R10 -2.5 down", 64'hC004000000000000, 1, 0, 1, 2'b11, 0, 1, 32'hFFFFFFFD);
    run("R10 -2.5 tozero", 64'hC004000000000000, 1, 0, 1, 2'b01, 0, 1, 32'hFFFFFFFE);
    run("R10 inx_en blocks", 64'h4004000000000000, 1, 0, 1, 2'b10, 1, 1, 32'h2);
    run("R11 frac carry", 64'h3FEFFFFFFFFFFFFF, 1, 1, 1, 2'b00, 0, 1, 32'h7FFFFFFF);
    run("R11 uns carry", 64'h41EFFFFFFFFFFFFF, 0, 0, 1, 2'b00, 0, 1, 32'hFFFFFFFF);
    run("R9 tiny", 64'h3E00000000000000, 0, 0, 0, 0, 0, 1, 32'h0);
    run("R9 shift32", 64'h3FE0000000000000, 0, 0, 0, 0, 0, 1, 32'h0);

    // R12 back-pressure
    @(negedge clk);
    in_op = 64'h4014000000000000; in_signed = 1; in_frac = 0; in_round = 0; in_valid = 1; out_ready = 0;
    e1 = model(64'h4014000000000000, 1, 0, 0, 0, 0);
    @(negedge clk);
    in_op = 64'h4020000000000000;
    chk("R12 stall ready", {35'h0, out_valid, in_ready}, 37'h2);
    repeat (2) @(negedge clk);
    chk("R12 hold", {out_res, out_inv, out_ovf, out_guard, out_sticky, out_inexact}, e1);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R12 next", {out_res, out_inv, out_ovf, out_guard, out_sticky, out_inexact},
        model(64'h4020000000000000, 1, 0, 0, 0, 0));

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] op;
      int pick = int'($urandom % 16);
      logic [10:0] ex;
      if (pick == 0) ex = 11'h7FF;
      else if (pick == 1) ex = 11'h0;
      else ex = 11'(990 + int'($urandom % 70));
      op = {1'($urandom), ex, 20'($urandom), 32'($urandom)};
      if (pick == 2) op[20:0] = '0;
      if (pick == 3) op[51:0] = '0;
      run(ex == 11'h7FF ? "R2 rnd" : "R9 rnd", op, 1'($urandom), 1'($urandom), 1'($urandom),
          2'($urandom), 1'(($urandom % 4) == 0), 0, 32'h0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule